// File: doc/BRIEF.md
# Bus Timeout Error Status Register

This block records bus transfer timeouts for the two masters of a shared on-chip bus. Each master has a 4-bit status group. The group holds a timeout flag, a read/write flag, a status lock and an address lock. A timeout event from a master sets that master's flag and records the direction of the failed transfer. The failing address goes into one shared address register.

Software reads both registers through a simple register port. Status bits are cleared by writing one to them. A per-master lock-enable input decides whether a captured error also freezes the master's group and the shared address. Later errors then cannot overwrite the evidence until software releases the locks.

Master 0 is the processor-side interface and master 1 is the PCI-side interface.

Top module: `bus_tmo_err_status`

## Requirements
- R1: After the active-low asynchronous reset, both registers read zero. Status bits 8 to 31 always read zero.
- R2: A timeout from master m whose status lock is clear sets bit 4m (error flag). In the same edge it loads bit 4m+1 with 1 for a read and 0 for a write. The status register is at offset 0.
- R3: A write to offset 0 clears every status bit written with 1. Bits written with 0 keep their value.
- R4: While bit 4m+2 (status lock) is set, timeouts from master m leave bits 4m and 4m+1 unchanged.
- R5: A captured timeout from master m with its lock-enable high sets bit 4m+2 and bit 4m+3 (address lock) on the same edge.
- R6: Offset 1 holds the address of the latest captured timeout. It does not load while any address lock bit is set.
- R7: When both masters capture on the same edge, each group updates independently and the address of master 0 is stored.
- R8: When a software clear and a hardware capture hit the same bit on the same edge, the bit ends set.
- R9: A lock held by one master never blocks status capture for the other master.
- R10: Writes to offset 1, and writes to reserved status bits, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_ofs_i | input | OFS_W (2) | Word offset: 0 status, 1 address |
| reg_wdata_i | input | DW (32) | Write data (write-one-to-clear at offset 0) |
| reg_rdata_o | output | DW (32) | Read data for reg_ofs_i |
| tmo_valid_i | input | NUM_MST (2) | Per-master timeout event |
| tmo_read_i | input | NUM_MST (2) | Per-master direction, 1 = read |
| tmo_lock_en_i | input | NUM_MST (2) | Per-master lock on capture |
| tmo_addr_i | input | NUM_MST*AW (64) | Per-master failing address, master m at [m*AW +: AW] |

## Verification
The hardest states to reach are the collisions. One is a clear and a capture on the same bit in one edge. Another is both masters failing together while one of them is locked, or while an address lock from an earlier error is still held. Directed sequences first build each lock state. They then fire a timeout and a clear together on the same cycle, and a random phase mixes clears, locks and dual events. A behavioural model follows every edge, and the bench reads both offsets after each clock.

// File: rtl/bus_tmo_pkg.sv
package bus_tmo_pkg;
  localparam int unsigned FIELD_W = 4;

  // bit 0 error, bit 1 read, bit 2 status lock, bit 3 address lock
  typedef struct packed {
    logic alk;
    logic flk;
    logic rd;
    logic err;
  } mst_field_t;
endpackage

// File: rtl/tmo_field.sv
module tmo_field
  import bus_tmo_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tmo_i,
  input  logic               rd_i,
  input  logic               lock_en_i,
  input  logic [FIELD_W-1:0] clr_i,
  output mst_field_t         field_o,
  output logic               cap_o
);
  mst_field_t q;
  logic       cap;

  assign cap     = tmo_i & ~q.flk;
  assign cap_o   = cap;
  assign field_o = q;

  // hardware set dominates a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else begin
      q.err <= cap | (q.err & ~clr_i[0]);
      q.rd  <= cap ? rd_i : (q.rd & ~clr_i[1]);
      q.flk <= (cap & lock_en_i) | (q.flk & ~clr_i[2]);
      q.alk <= (cap & lock_en_i) | (q.alk & ~clr_i[3]);
    end
  end

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !q.flk) |=> (q.err && (q.rd == $past(rd_i))));

  p_lock_freeze_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q.flk && !clr_i[0] && !clr_i[1]) |=> ($stable(q.err) && $stable(q.rd)));

  p_lock_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !q.flk && lock_en_i) |=> (q.flk && q.alk));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && !q.flk && clr_i[0]) |=> q.err);
endmodule

// File: rtl/tmo_addr_cap.sv
module tmo_addr_cap #(
  parameter int unsigned NUM_MST = 2,
  parameter int unsigned AW      = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_MST-1:0]    cap_i,
  input  logic [NUM_MST*AW-1:0] addr_i,
  input  logic                  hold_i,
  output logic [AW-1:0]         addr_o
);
  logic [AW-1:0] addr_q;
  logic [AW-1:0] sel;
  logic          load;

  // lowest master index wins
  always_comb begin
    sel = '0;
    for (int i = NUM_MST - 1; i >= 0; i--) begin
      if (cap_i[i]) sel = addr_i[i*AW +: AW];
    end
  end

  assign load   = (|cap_i) & ~hold_i;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (load) addr_q <= sel;
  end

  p_addr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(addr_q));

  p_m0_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i[0] && !hold_i) |=> (addr_q == $past(addr_i[AW-1:0])));
endmodule

// File: rtl/bus_tmo_err_status.sv
module bus_tmo_err_status
  import bus_tmo_pkg::*;
#(
  parameter int unsigned NUM_MST = 2,
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned OFS_W   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [OFS_W-1:0]      reg_ofs_i,
  input  logic [DW-1:0]         reg_wdata_i,
  output logic [DW-1:0]         reg_rdata_o,
  input  logic [NUM_MST-1:0]    tmo_valid_i,
  input  logic [NUM_MST-1:0]    tmo_read_i,
  input  logic [NUM_MST-1:0]    tmo_lock_en_i,
  input  logic [NUM_MST*AW-1:0] tmo_addr_i
);
  localparam int unsigned STAT_W   = NUM_MST * FIELD_W;
  localparam logic [OFS_W-1:0] OFS_STAT = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_ADDR = OFS_W'(1);

  logic                stat_wr;
  logic [STAT_W-1:0]   stat_vec;
  logic [NUM_MST-1:0]  cap;
  logic [NUM_MST-1:0]  alk_vec;
  logic [AW-1:0]       err_addr;

  assign stat_wr = reg_we_i && (reg_ofs_i == OFS_STAT);

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    mst_field_t fld;
    tmo_field u_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tmo_i     (tmo_valid_i[m]),
      .rd_i      (tmo_read_i[m]),
      .lock_en_i (tmo_lock_en_i[m]),
      .clr_i     (reg_wdata_i[m*FIELD_W +: FIELD_W] & {FIELD_W{stat_wr}}),
      .field_o   (fld),
      .cap_o     (cap[m])
    );
    assign stat_vec[m*FIELD_W +: FIELD_W] = fld;
    assign alk_vec[m] = fld.alk;
  end

  tmo_addr_cap #(
    .NUM_MST (NUM_MST),
    .AW      (AW)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .addr_i (tmo_addr_i),
    .hold_i (|alk_vec),
    .addr_o (err_addr)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_ofs_i == OFS_STAT)      reg_rdata_o[STAT_W-1:0] = stat_vec;
    else if (reg_ofs_i == OFS_ADDR) reg_rdata_o[AW-1:0]     = err_addr;
  end

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_ofs_i == OFS_STAT) |-> (reg_rdata_o[DW-1:STAT_W] == '0));

  p_addr_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_ofs_i == OFS_ADDR && cap == '0) |=> $stable(err_addr));

  p_other_master_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_vec[2] && !stat_vec[FIELD_W+2] && tmo_valid_i[1]) |=> stat_vec[FIELD_W]);
endmodule

// File: tb/bus_tmo_err_status_bench.sv
`timescale 1ns/1ps
module bus_tmo_err_status_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [1:0]    reg_ofs_i = '0;
  logic [DW-1:0] reg_wdata_i = '0;
  logic [DW-1:0] reg_rdata_o;
  logic [1:0]    tmo_valid_i = '0;
  logic [1:0]    tmo_read_i = '0;
  logic [1:0]    tmo_lock_en_i = '0;
  logic [2*AW-1:0] tmo_addr_i = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  bit m_err[2], m_rd[2], m_flk[2], m_alk[2];
  logic [31:0] m_addr;

  always #10 clk_i = ~clk_i;

  bus_tmo_err_status u_bus_tmo_err_status (
    .clk_i, .rst_ni, .reg_we_i, .reg_ofs_i, .reg_wdata_i, .reg_rdata_o,
    .tmo_valid_i, .tmo_read_i, .tmo_lock_en_i, .tmo_addr_i
  );

  function automatic logic [31:0] exp_stat();
    logic [31:0] v = '0;
    for (int m = 0; m < 2; m++) begin
      v[4*m]   = m_err[m];
      v[4*m+1] = m_rd[m];
      v[4*m+2] = m_flk[m];
      v[4*m+3] = m_alk[m];
    end
    return v;
  endfunction

  task automatic check_regs(string tag);
    reg_ofs_i = 2'd0; #1;
    n_chk++;
    if (reg_rdata_o !== exp_stat()) begin
      n_err++;
      $display("FAIL %s status got %h exp %h", tag, reg_rdata_o, exp_stat());
    end
    reg_ofs_i = 2'd1; #1;
    n_chk++;
    if (reg_rdata_o !== m_addr) begin
      n_err++;
      $display("FAIL %s address got %h exp %h", tag, reg_rdata_o, m_addr);
    end
    reg_ofs_i = 2'd2; #1;
    n_chk++;
    if (reg_rdata_o !== '0) begin
      n_err++;
      $display("FAIL %s unused offset got %h exp 0", tag, reg_rdata_o);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(string tag, bit we, logic [1:0] ofs, logic [31:0] wd,
                     logic [1:0] tv, logic [1:0] rd, logic [1:0] le,
                     logic [31:0] a0, logic [31:0] a1);
    bit cap[2];
    bit anyalk;
    logic [3:0] clr;
    reg_we_i = we; reg_ofs_i = ofs; reg_wdata_i = wd;
    tmo_valid_i = tv; tmo_read_i = rd; tmo_lock_en_i = le;
    tmo_addr_i = {a1, a0};
    @(posedge clk_i);
    anyalk = m_alk[0] | m_alk[1];
    for (int m = 0; m < 2; m++) cap[m] = tv[m] && !m_flk[m];
    if (!anyalk) begin
      if (cap[0]) m_addr = a0;
      else if (cap[1]) m_addr = a1;
    end
    for (int m = 0; m < 2; m++) begin
      clr = (we && ofs == 2'd0) ? wd[4*m +: 4] : 4'b0;
      if (cap[m]) begin
        m_err[m] = 1; m_rd[m] = rd[m];
      end else begin
        if (clr[0]) m_err[m] = 0;
        if (clr[1]) m_rd[m] = 0;
      end
      if (cap[m] && le[m]) begin
        m_flk[m] = 1; m_alk[m] = 1;
      end else begin
        if (clr[2]) m_flk[m] = 0;
        if (clr[3]) m_alk[m] = 0;
      end
    end
    @(negedge clk_i);
    reg_we_i = 0; tmo_valid_i = '0;
    check_regs(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 2'd0, 32'h0, 2'b00, 2'b00, 2'b00, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      m_err[m] = 0; m_rd[m] = 0; m_flk[m] = 0; m_alk[m] = 0;
    end
    m_addr = '0;
    repeat (3) @(negedge clk_i);
    check_regs("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_regs("R1 after reset");

    // R2: read on master 0, write on master 1
    cyc("R2 m0 read", 0, 0, 0, 2'b01, 2'b01, 2'b00, 32'hA000_0010, 32'h0);
    cyc("R2 m1 write", 0, 0, 0, 2'b10, 2'b00, 2'b00, 32'h0, 32'hB000_0020);
    cyc("R2 m0 write overwrites", 0, 0, 0, 2'b01, 2'b00, 2'b00, 32'hA000_0030, 32'h0);
    // R3: zeros do nothing, ones clear
    cyc("R3 write zero", 1, 0, 32'h0, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R2 m1 read", 0, 0, 0, 2'b10, 2'b10, 2'b00, 32'h0, 32'hB000_0040);
    cyc("R3 clear m1 rd only", 1, 0, 32'h0000_0020, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R3 clear all", 1, 0, 32'h0000_00FF, 2'b00, 2'b00, 2'b00, 0, 0);
    // R5 / R4 / R6: lock master 0
    cyc("R5 m0 lock", 0, 0, 0, 2'b01, 2'b01, 2'b01, 32'hC000_0100, 32'h0);
    cyc("R4 m0 frozen", 0, 0, 0, 2'b01, 2'b00, 2'b01, 32'hC000_0200, 32'h0);
    // R9 + R6: master 1 still captures, address held
    cyc("R9 m1 captures while m0 locked", 0, 0, 0, 2'b10, 2'b00, 2'b00, 32'h0, 32'hD000_0300);
    // R10: offset 1 write and reserved bits ignored
    cyc("R10 addr write", 1, 1, 32'hFFFF_FFFF, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R10 reserved write", 1, 0, 32'hFFFF_FF00, 2'b00, 2'b00, 2'b00, 0, 0);
    // R4: clear err while locked, flag stays clear
    cyc("R4 clear err keep lock", 1, 0, 32'h0000_0001, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R4 timeout ignored", 0, 0, 0, 2'b01, 2'b01, 2'b00, 32'hC000_0400, 32'h0);
    // R6: release field lock only, address still held
    cyc("R6 release flk", 1, 0, 32'h0000_0004, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R6 addr held by alk", 0, 0, 0, 2'b01, 2'b00, 2'b00, 32'hC000_0500, 32'h0);
    cyc("R6 release alk", 1, 0, 32'h0000_0008, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R6 addr loads", 0, 0, 0, 2'b10, 2'b01, 2'b00, 32'h0, 32'hD000_0600);
    // R7: both masters together
    cyc("R3 clear all", 1, 0, 32'h0000_00FF, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R7 dual event", 0, 0, 0, 2'b11, 2'b10, 2'b10, 32'hE000_0700, 32'hF000_0800);
    cyc("R3 clear all", 1, 0, 32'h0000_00FF, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R7 dual m0 locked before", 0, 0, 0, 2'b01, 2'b00, 2'b01, 32'hE000_0900, 0);
    cyc("R7 dual with m0 locked", 0, 0, 0, 2'b11, 2'b11, 2'b00, 32'hE000_0A00, 32'hF000_0B00);
    // R8: clear and capture on same edge
    cyc("R3 clear all", 1, 0, 32'h0000_00FF, 2'b00, 2'b00, 2'b00, 0, 0);
    cyc("R8 m1 capture with clear", 1, 0, 32'h0000_00F0, 2'b10, 2'b10, 2'b10, 32'h0, 32'h1234_5678);
    cyc("R8 m0 capture with clear", 1, 0, 32'h0000_000F, 2'b01, 2'b01, 2'b00, 32'h9, 32'h0);
    idle("R1 idle");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r = $urandom;
      cyc("R2 R3 R4 R5 R6 R7 R8 random", r[0] & r[1], {1'b0, r[2] & r[3]},
          $urandom, r[5:4], r[7:6], {r[9] & r[10], r[11] & r[12]},
          $urandom, $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule